// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for every data beat of an SDRAM read or write burst. When a column command (read or write) is accepted, it captures an 8-bit starting column together with the programmed burst length, burst ordering and single-write setting. From the next cycle onward it presents one column per clock with a valid strobe, and it marks the final beat of fixed-length bursts.

Two orderings are supported. Sequential order counts upward and wraps inside the aligned block. Interleaved order XORs the low bits of the start column with the beat index. A page-length mode walks all columns upward, wrapping from the top column back to zero, until a stop or a new command arrives.

A stop input truncates any burst. A new column command on any cycle restarts the sequence from its own column. Data movement, read latency and bank or row tracking belong to other blocks.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While reset is asserted and after its release with no command, `beatValid` and `beatLast` are low.
- R2: In sequential order with length N (1, 2, 4 or 8), beat k carries the start column with its low log2(N) bits replaced by (start + k) mod N. The first beat appears in the cycle after the command is sampled.
- R3: In interleaved order with length N, beat k carries the start column with its low log2(N) bits replaced by start XOR k.
- R4: For lengths of 8 or less, the column bits above the low log2(N) bits equal those of the start column on every beat.
- R5: Page mode (length code 7) steps the column up by one per beat modulo 256 and ignores the ordering input. It runs until a stop or a new command, and it never raises `beatLast`.
- R6: A command sampled on any cycle restarts the burst from its own column, even mid-burst. It wins over a stop sampled in the same cycle.
- R7: A stop sampled while a burst is active, with no command, drops `beatValid` in the next cycle for every length, including page mode.
- R8: `beatLast` is high exactly on the final beat of a fixed-length burst, and `beatValid` falls in the next cycle unless a new command was sampled.
- R9: When single-write mode is set, a write command yields exactly one beat with `beatLast`. A read in the same mode follows the programmed length.
- R10: Length codes are 0=1, 1=2, 2=4, 3=8, 7=page. Codes 4 to 6 act as length 1. The mode inputs are sampled only with a command, and later changes do not affect the running burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Read or write column command this cycle |
| cmdIsWrite | input | 1 | Command is a write |
| cmdCol | input | 8 | Starting column of the command |
| burstStop | input | 1 | Truncate the running burst |
| modeLen | input | 3 | Burst length code |
| modeInterleave | input | 1 | 1 = interleaved order, 0 = sequential |
| modeWriteSingle | input | 1 | Writes use a single beat |
| beatValid | output | 1 | A beat column is presented |
| beatCol | output | 8 | Column of the current beat |
| beatLast | output | 1 | Final beat of a fixed-length burst |

## Verification
Several rules are checked by assertions on every cycle: a command starts a beat in the next cycle, and a stop or final beat ends the burst. They also check that `beatLast` only appears with a valid beat and never in page mode, that upper column bits hold during fixed bursts, and that page mode increments by one. The exact beat orderings can only be shown by the bench's scenarios, which compare each beat against a reference model. These include the listed sequential and interleaved orders, the wrap from 255 to 0, single-write shortening, reserved codes and mode changes mid-burst.

// File: rtl/sdram_colgen_pkg.sv
package sdram_colgen_pkg;

  localparam logic [2:0] LEN_ONE   = 3'd0;
  localparam logic [2:0] LEN_TWO   = 3'd1;
  localparam logic [2:0] LEN_FOUR  = 3'd2;
  localparam logic [2:0] LEN_EIGHT = 3'd3;
  localparam logic [2:0] LEN_PAGE  = 3'd7;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // capture a new start column, reset beat index
    logic step;   // advance to the next beat
  } colStrobe_t;

endpackage

// File: rtl/sdram_colgen_ctrl.sv
module sdram_colgen_ctrl
  import sdram_colgen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmdValid,
  input  logic             cmdIsWrite,
  input  logic             burstStop,
  input  logic [2:0]       modeLen,
  input  logic             modeInterleave,
  input  logic             modeWriteSingle,
  output colStrobe_t       strobe,
  output logic [COL_W-1:0] beatMask,
  output logic             interleaveSel,
  output logic             pageMode,
  output logic             beatValid,
  output logic             beatLast
);

  localparam logic [COL_W-1:0] MASK_ALL = {COL_W{1'b1}};

  logic             activeQ;
  logic             pageQ;
  logic             ilQ;
  logic [COL_W-1:0] maskQ;
  logic [COL_W-1:0] cntQ;

  logic             forceSingle;
  logic [COL_W-1:0] maskReq;
  logic             pageReq;
  logic             finalBeat;
  logic             endNow;

  // length decode at command time
  always_comb begin
    forceSingle = cmdIsWrite && modeWriteSingle;
    pageReq     = 1'b0;
    unique case (modeLen)
      LEN_TWO:   maskReq = COL_W'(1);
      LEN_FOUR:  maskReq = COL_W'(3);
      LEN_EIGHT: maskReq = COL_W'(7);
      LEN_PAGE: begin
        maskReq = MASK_ALL;
        pageReq = 1'b1;
      end
      default:   maskReq = '0;
    endcase
    if (forceSingle) begin
      maskReq = '0;
      pageReq = 1'b0;
    end
  end

  assign finalBeat = activeQ && !pageQ && (cntQ == maskQ);
  assign endNow    = burstStop || finalBeat;

  always_comb begin
    strobe.load = cmdValid;
    strobe.step = !cmdValid && activeQ && !endNow;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      activeQ <= 1'b0;
      pageQ   <= 1'b0;
      ilQ     <= 1'b0;
      maskQ   <= '0;
      cntQ    <= '0;
    end else if (cmdValid) begin
      activeQ <= 1'b1;
      pageQ   <= pageReq;
      ilQ     <= modeInterleave && !pageReq;
      maskQ   <= maskReq;
      cntQ    <= '0;
    end else if (activeQ) begin
      if (endNow) begin
        activeQ <= 1'b0;
      end else begin
        cntQ <= cntQ + 1'b1;
      end
    end
  end

  assign beatMask      = maskQ;
  assign interleaveSel = ilQ;
  assign pageMode      = pageQ;
  assign beatValid     = activeQ;
  assign beatLast      = finalBeat;

  // R6
  cmd_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmdValid |=> beatValid);

  // R7
  stop_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beatValid && burstStop && !cmdValid) |=> !beatValid);

  // R8
  last_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beatLast && !cmdValid) |=> !beatValid);

  // R8
  last_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beatLast |-> beatValid);

  // R5
  page_no_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pageMode |-> !beatLast);

endmodule

// File: rtl/sdram_colgen_dp.sv
module sdram_colgen_dp
  import sdram_colgen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  colStrobe_t       strobe,
  input  logic [COL_W-1:0] cmdCol,
  input  logic [COL_W-1:0] beatMask,
  input  logic             interleaveSel,
  input  logic             pageMode,
  output logic [COL_W-1:0] colOut
);

  localparam logic [COL_W-1:0] MASK_ALL = {COL_W{1'b1}};

  logic [COL_W-1:0] baseQ;
  logic [COL_W-1:0] idxQ;
  logic [COL_W-1:0] seqLow;
  logic [COL_W-1:0] ilLow;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      baseQ <= '0;
      idxQ  <= '0;
    end else if (strobe.load) begin
      baseQ <= cmdCol;
      idxQ  <= '0;
    end else if (strobe.step) begin
      idxQ <= idxQ + 1'b1;
    end
  end

  assign seqLow = (baseQ + idxQ) & beatMask;
  assign ilLow  = (baseQ ^ idxQ) & beatMask;
  assign colOut = (baseQ & ~beatMask) | (interleaveSel ? ilLow : seqLow);

  // R4
  upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.step && !pageMode) |=> $stable(colOut & ~beatMask));

  // R5
  page_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.step && pageMode && beatMask == MASK_ALL)
      |=> (colOut == COL_W'($past(colOut) + 1'b1)));

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import sdram_colgen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmdValid,
  input  logic             cmdIsWrite,
  input  logic [COL_W-1:0] cmdCol,
  input  logic             burstStop,
  input  logic [2:0]       modeLen,
  input  logic             modeInterleave,
  input  logic             modeWriteSingle,
  output logic             beatValid,
  output logic [COL_W-1:0] beatCol,
  output logic             beatLast
);

  colStrobe_t       strobe;
  logic [COL_W-1:0] beatMask;
  logic             interleaveSel;
  logic             pageMode;

  sdram_colgen_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmdValid       (cmdValid),
    .cmdIsWrite     (cmdIsWrite),
    .burstStop      (burstStop),
    .modeLen        (modeLen),
    .modeInterleave (modeInterleave),
    .modeWriteSingle(modeWriteSingle),
    .strobe         (strobe),
    .beatMask       (beatMask),
    .interleaveSel  (interleaveSel),
    .pageMode       (pageMode),
    .beatValid      (beatValid),
    .beatLast       (beatLast)
  );

  sdram_colgen_dp #(.COL_W(COL_W)) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobe       (strobe),
    .cmdCol       (cmdCol),
    .beatMask     (beatMask),
    .interleaveSel(interleaveSel),
    .pageMode     (pageMode),
    .colOut       (beatCol)
  );

endmodule

// File: tb/sdram_burst_colgen_bench.sv
module sdram_burst_colgen_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmdValid = 1'b0;
  logic       cmdIsWrite = 1'b0;
  logic [7:0] cmdCol = '0;
  logic       burstStop = 1'b0;
  logic [2:0] modeLen = '0;
  logic       modeInterleave = 1'b0;
  logic       modeWriteSingle = 1'b0;
  logic       beatValid;
  logic [7:0] beatCol;
  logic       beatLast;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // reference model state
  bit       mActive = 0;
  bit       mPage = 0;
  bit       mIl = 0;
  bit [7:0] mMask = 0;
  bit [7:0] mBase = 0;
  bit [7:0] mIdx = 0;
  string    pendTag = "R1";

  always #5 clk = ~clk;

  sdram_burst_colgen u_sdram_burst_colgen (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdIsWrite(cmdIsWrite),
    .cmdCol(cmdCol), .burstStop(burstStop), .modeLen(modeLen),
    .modeInterleave(modeInterleave), .modeWriteSingle(modeWriteSingle),
    .beatValid(beatValid), .beatCol(beatCol), .beatLast(beatLast)
  );

  // R10: length code to mask (length-1)
  function automatic bit [7:0] lenMask(input bit [2:0] code);
    case (code)
      3'd1: return 8'd1;
      3'd2: return 8'd3;
      3'd3: return 8'd7;
      3'd7: return 8'hFF;
      default: return 8'd0;
    endcase
  endfunction

  // R2, R3, R4: expected column of beat idx
  function automatic bit [7:0] expCol(input bit [7:0] base, input bit [7:0] idx,
                                      input bit [7:0] mask, input bit il);
    bit [7:0] low;
    low = il ? ((base ^ idx) & mask) : ((base + idx) & mask);
    return (base & ~mask) | low;
  endfunction

  task automatic compareNow(input string tag);
    bit       eValid;
    bit       eLast;
    bit [7:0] eCol;
    eValid = mActive;
    eLast  = mActive && !mPage && (mIdx == mMask);
    eCol   = expCol(mBase, mIdx, mMask, mIl);
    checks++;
    if (beatValid !== eValid || beatLast !== eLast ||
        (eValid && beatCol !== eCol)) begin
      failures++;
      $display("FAIL %s: valid=%0b col=%02h last=%0b expected valid=%0b col=%02h last=%0b",
               tag, beatValid, beatCol, beatLast, eValid, eCol, eLast);
    end
  endtask

  // one clock: check outputs at negedge, drive new inputs, advance model
  task automatic cyc(input bit c, input bit w, input bit [7:0] col, input bit stop,
                     input bit [2:0] len, input bit il, input bit sw, input string tag);
    bit single;
    bit [7:0] m;
    @(negedge clk);
    compareNow(pendTag);
    cmdValid = c; cmdIsWrite = w; cmdCol = col; burstStop = stop;
    modeLen = len; modeInterleave = il; modeWriteSingle = sw;
    pendTag = tag;
    if (c) begin
      single = w && sw;
      m = single ? 8'd0 : lenMask(len);
      mActive = 1; mPage = !single && (len == 3'd7);
      mIl = il && !mPage; mMask = m; mBase = col; mIdx = 0;
    end else if (mActive) begin
      if (stop || (!mPage && mIdx == mMask)) mActive = 0;
      else mIdx = mIdx + 1;
    end
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, 8'h00, 0, 3'd0, 0, 0, tag);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    checks++;
    if (beatValid !== 1'b0 || beatLast !== 1'b0) begin
      failures++;
      $display("FAIL R1: valid=%0b last=%0b expected 0 0", beatValid, beatLast);
    end
    rst_n = 1'b1;
    idle(2, "R1");

    // R2: length 4 sequential from 0x41 -> 41 42 43 40
    cyc(1, 0, 8'h41, 0, 3'd2, 0, 0, "R2");
    idle(6, "R2");
    // R3: length 8 interleaved from 0x95 -> 95 94 97 96 91 90 93 92
    cyc(1, 0, 8'h95, 0, 3'd3, 1, 0, "R3");
    idle(10, "R3");
    // R4: length 2 from 0xFF keeps upper bits -> FF FE
    cyc(1, 1, 8'hFF, 0, 3'd1, 0, 0, "R4");
    idle(4, "R4");
    // R5: page mode from 0xFA, ordering input set, wraps past 0xFF
    cyc(1, 0, 8'hFA, 0, 3'd7, 1, 0, "R5");
    idle(12, "R5");
    // R7: stop ends page burst
    cyc(0, 0, 8'h00, 1, 3'd0, 0, 0, "R7");
    idle(3, "R7");
    // R7: stop ends a length-8 burst early
    cyc(1, 0, 8'h30, 0, 3'd3, 0, 0, "R7");
    idle(2, "R7");
    cyc(0, 0, 8'h00, 1, 3'd0, 0, 0, "R7");
    idle(3, "R7");
    // R6: restart mid-burst; command beats simultaneous stop
    cyc(1, 0, 8'h10, 0, 3'd3, 0, 0, "R6");
    idle(3, "R6");
    cyc(1, 0, 8'h22, 1, 3'd2, 1, 0, "R6");
    idle(6, "R6");
    // R8: single beat burst, last on first beat
    cyc(1, 0, 8'h77, 0, 3'd0, 0, 0, "R8");
    idle(3, "R8");
    // R8: back-to-back command on the last beat
    cyc(1, 0, 8'h02, 0, 3'd1, 0, 0, "R8");
    cyc(0, 0, 8'h00, 0, 3'd0, 0, 0, "R8");
    cyc(1, 0, 8'h05, 0, 3'd1, 1, 0, "R8");
    idle(4, "R8");
    // R9: single-write mode shortens writes only
    cyc(1, 1, 8'h60, 0, 3'd3, 0, 1, "R9");
    idle(3, "R9");
    cyc(1, 0, 8'h60, 0, 3'd3, 0, 1, "R9");
    idle(10, "R9");
    cyc(1, 1, 8'h60, 0, 3'd7, 0, 1, "R9");
    idle(3, "R9");
    // R10: reserved code acts as length 1; mode change mid-burst ignored
    cyc(1, 0, 8'hA3, 0, 3'd5, 0, 0, "R10");
    idle(3, "R10");
    cyc(1, 0, 8'hC6, 0, 3'd2, 0, 0, "R10");
    cyc(0, 1, 8'h00, 0, 3'd7, 1, 1, "R10");
    cyc(0, 1, 8'h00, 0, 3'd0, 1, 1, "R10");
    idle(4, "R10");

    // mixed random traffic
    for (int i = 0; i < 4000; i++) begin
      bit c;
      bit s;
      bit [2:0] codes [5] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd7};
      bit [2:0] len;
      c = ($urandom % 6) == 0;
      s = ($urandom % 25) == 0;
      len = (($urandom % 10) == 0) ? 3'(4 + $urandom % 3) : codes[$urandom % 5];
      cyc(c, 1'($urandom), 8'($urandom), s, len, 1'($urandom),
          (($urandom % 4) == 0), "R2/R3 random");
    end
    idle(2, "R7");
    finish_run();
  end

endmodule